// File: doc/BRIEF.md
# Handshaked Serial-to-Parallel Receiver

This block collects a short serial word from an external source and hands it to a processor-side register as one parallel word. The source asks for a transfer with a one-cycle ready pulse. The receiver answers with a one-cycle acknowledge. It then drives a shift clock back to the source, at half the system clock rate, for exactly one word's worth of bits. The serial line is sampled as each shift clock rises, and the bits are assembled in a shift register. Each new bit enters at the top and the older bits move down, so the first bit received ends up in bit 0.

Once the last bit is in, a word-done flag rises and stays up. The word moves to the processor-facing output register only when the processor side pulses commit, which also produces a one-cycle valid strobe. The processor pulls the word with commit whenever it likes. Because of that there is no back-pressure on the output side: the held word simply waits, and a commit given while no word is waiting does nothing. All pins are plain control and data lines. The receiver itself sets the pace of the serial side, so no ready/valid pair is needed there either.

Top module: `s2p_handshake_if`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released, src_ack_o, src_sclk_o, par_valid_o and word_done_o are 0 and par_word_o is all zeros. Reset is asynchronous and also returns the control logic to idle.
- R2: When src_ready_i is sampled high at a clock edge while the block is idle, src_ack_o is high for exactly one cycle. That cycle is the second cycle after the edge (the ready cycle counts as cycle -1, the ack cycle is cycle 1).
- R3: Right after the ack cycle, src_sclk_o gives exactly WORD_W high pulses, each one cycle high and one cycle low. The pulses are high in cycles 2, 4, ..., 2*WORD_W, and src_sclk_o is low at all other times.
- R4: The src_sdata_i value present in the cycle before each src_sclk_o high cycle is captured at the edge that raises src_sclk_o. Bits enter at the MSB and shift toward the LSB, so the first bit captured is bit 0 of the word and the last is bit WORD_W-1.
- R5: A src_ready_i pulse sampled while a transfer is in progress (cycles 0 to 2*WORD_W) is ignored: no second ack and no extra shift clocks follow, and the word in progress is not disturbed.
- R6: word_done_o rises in cycle 2*WORD_W+1, the cycle after the last shift-clock high cycle. It stays high until a commit transfers the word.
- R7: A proc_commit_i pulse sampled while word_done_o is 0 has no effect: par_word_o keeps its value and par_valid_o stays 0.
- R8: A proc_commit_i pulse sampled while word_done_o is 1 loads the assembled word into par_word_o at that edge. par_valid_o is high for exactly that one following cycle, and word_done_o is cleared at the same edge.
- R9: After a transfer completes, the block is idle again and a new ready pulse starts a new transfer with the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_ready_i | input | 1 | One-cycle transfer request from the serial source |
| src_ack_o | output | 1 | One-cycle acknowledge to the source |
| src_sclk_o | output | 1 | Shift clock driven to the source |
| src_sdata_i | input | 1 | Serial data from the source |
| proc_commit_i | input | 1 | Commit pulse that moves the held word to the output |
| par_word_o | output | WORD_W | Processor-facing parallel word |
| par_valid_o | output | 1 | One-cycle strobe when par_word_o is loaded |
| word_done_o | output | 1 | A complete word is waiting to be committed |

## Verification
The assertions assume that src_ready_i and proc_commit_i are pulses that are only acted on at clock edges. They also assume that the source keeps src_sdata_i steady across each sampling edge. The bench drives every input at the falling clock edge, and it presents each new serial bit after the ack or a shift-clock high cycle, just as the source would. Ready pulses are placed both in idle and inside the busy window, and commit pulses both before and after word-done. Random words and random delays come from a seeded generator, and directed cases cover the all-zeros and all-ones words and a reset in the middle of a transfer.

// File: rtl/s2p_pkg.sv
package s2p_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_ACK   = 2'd2,
    ST_SHIFT = 2'd3
  } s2p_state_e;
endpackage

// File: rtl/s2p_ctrl.sv
module s2p_ctrl
  import s2p_pkg::*;
#(
  parameter int WORD_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ready_i,
  output logic ack_o,
  output logic sclk_o,
  output logic capture_o,
  output logic last_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W);

  s2p_state_e       state_q;
  logic             phase_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE:  if (ready_i) state_q <= ST_WAIT;
        ST_WAIT:  state_q <= ST_ACK;
        ST_ACK: begin
          state_q <= ST_SHIFT;
          phase_q <= 1'b1;
          cnt_q   <= CNT_W'(1);
        end
        default: begin
          if (phase_q) begin
            phase_q <= 1'b0;
            if (cnt_q == CNT_LAST) begin
              state_q <= ST_IDLE;
              cnt_q   <= '0;
            end
          end else begin
            phase_q <= 1'b1;
            cnt_q   <= cnt_q + CNT_W'(1);
          end
        end
      endcase
    end
  end

  // capture on every edge that raises the shift clock
  assign capture_o = (state_q == ST_ACK) || ((state_q == ST_SHIFT) && !phase_q);
  assign last_o    = (state_q == ST_SHIFT) && phase_q && (cnt_q == CNT_LAST);
  assign ack_o     = (state_q == ST_ACK);
  assign sclk_o    = phase_q;
endmodule

// File: rtl/s2p_shreg.sv
module s2p_shreg #(
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o
);
  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    logic nxt;
    if (i == WORD_W - 1) begin : g_top
      assign nxt = bit_i;
    end else begin : g_mid
      assign nxt = word_o[i+1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_o[i] <= 1'b0;
      else if (shift_i) word_o[i] <= nxt;
    end
  end
endmodule

// File: rtl/s2p_outreg.sv
module s2p_outreg #(
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              last_i,
  input  logic              commit_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] par_word_o,
  output logic              par_valid_o,
  output logic              word_done_o
);
  logic take;
  assign take = commit_i && word_done_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_word_o  <= '0;
      par_valid_o <= 1'b0;
      word_done_o <= 1'b0;
    end else begin
      par_valid_o <= take;
      if (take) par_word_o <= word_i;
      if (last_i)    word_done_o <= 1'b1;
      else if (take) word_done_o <= 1'b0;
    end
  end
endmodule

// File: rtl/s2p_handshake_if.sv
module s2p_handshake_if #(
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_ready_i,
  output logic              src_ack_o,
  output logic              src_sclk_o,
  input  logic              src_sdata_i,
  input  logic              proc_commit_i,
  output logic [WORD_W-1:0] par_word_o,
  output logic              par_valid_o,
  output logic              word_done_o
);
  logic              capture;
  logic              last;
  logic [WORD_W-1:0] asm_word;

  s2p_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ready_i   (src_ready_i),
    .ack_o     (src_ack_o),
    .sclk_o    (src_sclk_o),
    .capture_o (capture),
    .last_o    (last)
  );

  s2p_shreg #(.WORD_W(WORD_W)) u_shreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_i (capture),
    .bit_i   (src_sdata_i),
    .word_o  (asm_word)
  );

  s2p_outreg #(.WORD_W(WORD_W)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .last_i      (last),
    .commit_i    (proc_commit_i),
    .word_i      (asm_word),
    .par_word_o  (par_word_o),
    .par_valid_o (par_valid_o),
    .word_done_o (word_done_o)
  );
endmodule

// File: rtl/s2p_if_chk.sv
module s2p_if_chk #(
  parameter int WORD_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              src_ready_i,
  input logic              src_ack_o,
  input logic              src_sclk_o,
  input logic              proc_commit_i,
  input logic [WORD_W-1:0] par_word_o,
  input logic              par_valid_o,
  input logic              word_done_o
);
  localparam int RC_W = $clog2(WORD_W + 2);

  logic            sclk_d;
  logic [RC_W-1:0] rises;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      rises  <= '0;
    end else begin
      sclk_d <= src_sclk_o;
      if (src_ack_o)                rises <= '0;
      else if (src_sclk_o && !sclk_d) rises <= rises + RC_W'(1);
    end
  end

  p_ack_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    src_ack_o |=> !src_ack_o);

  p_ack_after_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_ack_o) |-> $past(src_ready_i, 2));

  p_sclk_halfrate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    src_sclk_o |=> !src_sclk_o);

  p_sclk_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rises <= RC_W'(WORD_W));

  p_no_sclk_with_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_ack_o && src_sclk_o));

  p_word_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !par_valid_o |-> $stable(par_word_o));

  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    par_valid_o |=> !par_valid_o);

  p_valid_needs_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(par_valid_o) |-> $past(word_done_o) && $past(proc_commit_i));

  p_done_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done_o && !proc_commit_i) |=> word_done_o);
endmodule

bind s2p_handshake_if s2p_if_chk #(.WORD_W(WORD_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .src_ready_i   (src_ready_i),
  .src_ack_o     (src_ack_o),
  .src_sclk_o    (src_sclk_o),
  .proc_commit_i (proc_commit_i),
  .par_word_o    (par_word_o),
  .par_valid_o   (par_valid_o),
  .word_done_o   (word_done_o)
);

// File: tb/s2p_handshake_if_tb.sv
module s2p_handshake_if_tb;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         src_ready_i = 1'b0;
  logic         src_sdata_i = 1'b0;
  logic         proc_commit_i = 1'b0;
  logic         src_ack_o, src_sclk_o, par_valid_o, word_done_o;
  logic [W-1:0] par_word_o;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] prev_word = '0;

  always #5 clk = ~clk;

  s2p_handshake_if #(.WORD_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_ready_i(src_ready_i), .src_ack_o(src_ack_o),
    .src_sclk_o(src_sclk_o), .src_sdata_i(src_sdata_i), .proc_commit_i(proc_commit_i),
    .par_word_o(par_word_o), .par_valid_o(par_valid_o), .word_done_o(word_done_o)
  );

  function automatic logic exp_ack(int k);
    return k == 1;
  endfunction
  function automatic logic exp_sclk(int k);
    return (k >= 2) && (k <= 2 * W) && (k % 2 == 0);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_idle_outputs(string req);
    chk(req, {31'd0, src_ack_o}, 0);
    chk(req, {31'd0, src_sclk_o}, 0);
    chk(req, {31'd0, par_valid_o}, 0);
    chk(req, {31'd0, word_done_o}, 0);
    chk(req, {28'd0, par_word_o}, 0);
  endtask

  // busy_k: cycle for a stray ready (-1 none); early_k: cycle for an early commit (-1 none)
  task automatic run_transfer(logic [W-1:0] w, int busy_k, int early_k, int wait_n);
    int idx;
    idx = 0;
    @(negedge clk) src_ready_i = 1'b1;
    @(negedge clk) src_ready_i = 1'b0;
    for (int k = 0; k <= 2 * W + 1; k++) begin
      chk("R2 ack timing", {31'd0, src_ack_o}, {31'd0, exp_ack(k)});
      chk("R3 shift clock", {31'd0, src_sclk_o}, {31'd0, exp_sclk(k)});
      chk("R6 word_done", {31'd0, word_done_o}, {31'd0, k == 2 * W + 1});
      chk("R7 valid quiet", {31'd0, par_valid_o}, 0);
      chk("R7 word held", {28'd0, par_word_o}, {28'd0, prev_word});
      if ((src_ack_o || src_sclk_o) && idx < W) begin
        src_sdata_i = w[idx];
        idx++;
      end else if (src_ack_o || src_sclk_o) begin
        src_sdata_i = 1'($urandom);
      end
      src_ready_i   = (k == busy_k);
      proc_commit_i = (k == early_k);
      @(negedge clk);
    end
    src_ready_i   = 1'b0;
    proc_commit_i = 1'b0;
    for (int j = 0; j < wait_n; j++) begin
      chk("R5 no second ack", {31'd0, src_ack_o}, 0);
      chk("R5 no extra sclk", {31'd0, src_sclk_o}, 0);
      chk("R6 done held", {31'd0, word_done_o}, 1);
      @(negedge clk);
    end
    proc_commit_i = 1'b1;
    @(negedge clk) proc_commit_i = 1'b0;
    chk("R8 valid pulse", {31'd0, par_valid_o}, 1);
    chk("R4 R8 word value", {28'd0, par_word_o}, {28'd0, w});
    chk("R8 done cleared", {31'd0, word_done_o}, 0);
    prev_word = w;
    @(negedge clk);
    chk("R8 valid one cycle", {31'd0, par_valid_o}, 0);
    chk("R8 word kept", {28'd0, par_word_o}, {28'd0, w});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    #3;
    chk_idle_outputs("R1 in reset");
    @(negedge clk);
    @(negedge clk) rst_n = 1'b1;
    chk_idle_outputs("R1 after release");

    // directed corners
    run_transfer(4'b0001, -1, -1, 3);   // R4 first bit lands in bit 0
    run_transfer(4'b1000, -1, -1, 3);
    run_transfer(4'b1111, 3, 4, 4);     // R5 stray ready, R7 early commit
    run_transfer(4'b0000, 2 * W, 0, 3); // R5 ready in last busy cycle
    run_transfer(4'b1010, 0, 2 * W, 3); // R9 back-to-back reuse

    // reset in the middle of a transfer
    @(negedge clk) src_ready_i = 1'b1;
    @(negedge clk) src_ready_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    #1 chk_idle_outputs("R1 mid-transfer reset");
    @(negedge clk) rst_n = 1'b1;
    prev_word = '0;
    @(negedge clk);
    chk_idle_outputs("R1 idle after reset");
    run_transfer(4'b0110, -1, -1, 3);   // R9 works after reset

    // constrained random
    for (int n = 0; n < 40; n++) begin
      logic [W-1:0] w;
      int bk, ek;
      w  = W'($urandom);
      bk = ($urandom % 3 == 0) ? int'($urandom % (2 * W + 1)) : -1;
      ek = ($urandom % 3 == 0) ? int'($urandom % (2 * W + 1)) : -1;
      run_transfer(w, bk, ek, 3 + int'($urandom % 5));
      repeat ($urandom % 3) @(negedge clk);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule